// File: doc/BRIEF.md
# Coprocessor System Register File

This block is the bank of system control registers that a processor core reaches through its move-to-coprocessor and move-from-coprocessor commands. Each command arrives as one bundle: a valid bit, a direction bit, the primary register number, the secondary register number, a three-bit sub-opcode and a 32-bit write value. The three selector fields together pick the target. The target is a constant identification word, a stored configuration register, a fault record, or a maintenance operation.

Reads are combinational. The value appears on `rd_data` in the same cycle as the read command. Writes to stored registers take effect at the clock edge. Maintenance encodings hold no state. A write to one of them produces a one-cycle pulse on `maint_pulse` in the cycle after the command, and it latches the write value on `maint_arg` so the cache or TLB logic can use it as an address. Abort inputs from the memory system record the fault status, and for data aborts also the faulting address, without software involvement.

Top module: `sysreg_bank`

## Requirements
- R1: A read with primary number 0, secondary number 0 returns `ID_VALUE` for sub-opcode 0, `CTYPE_VALUE` for sub-opcode 1 and `TCM_VALUE` for sub-opcode 2. Writes to these encodings change nothing.
- R2: The translation base (primary 2, secondary 0, sub-opcode 0) stores only bits [31:14] of a written word. Reads and `ttb_out` show bits [13:0] as zero.
- R3: The following registers are fully readable and writable, 32 bits wide, at secondary 0: control (primary 1, sub 0), domain access (primary 3, sub 0), data lockdown (primary 9, sub 0), instruction lockdown (primary 9, sub 1) and TLB lockdown (primary 10, sub 0). Control resets to `CTRL_RESET` and is shown on `ctrl_out`. Domain access is shown on `dacr_out`.
- R4: With primary 5 and secondary 0, sub-opcode 0 selects the data fault status and sub-opcode 1 selects the instruction fault status. Each holds the low `FSR_W` bits of a write and reads with the upper bits zero. A data abort loads `dabort_fs` into the data fault status. A prefetch abort loads `pabort_fs` into the instruction fault status. An abort wins over a software write in the same cycle.
- R5: The fault address (primary 6, secondary 0, sub 0) is writable by software. A data abort loads it with `dabort_addr`. A prefetch abort never changes it.
- R6: Writes with primary 7 produce a single pulse on `maint_pulse` one cycle later. The bit index is chosen by the (secondary, sub-opcode) pair: bit 0 for (7,0) invalidate both caches, bit 1 for (5,0) invalidate instruction cache, bit 2 for (6,0) invalidate data cache, bit 3 for (13,1) prefetch instruction line, bit 4 for (10,4) drain write buffer, and bit 5 for (0,4) wait for interrupt. `maint_arg` then holds the write value.
- R7: Writes with primary 8 pulse bit 6 + 2*s + o of `maint_pulse`, where s is 0, 1 or 2 for secondary 7 (unified), 5 (instruction) or 6 (data), and o is the sub-opcode: 0 invalidates all entries, 1 invalidates a single entry. `maint_arg` holds the write value.
- R8: The process ID (primary 13, secondary 0, sub 0) is a 7-bit field at bits [31:25]. It resets to zero and is shown on `pid_out`.
- R9: A write to the context ID (primary 13, secondary 0, sub 1) stores the full word. The word is driven on `trace_pid`, and `trace_pid_wr` is high for exactly the one cycle after the write.
- R10: Encodings not listed above read as zero. Writes to them change no register and pulse nothing. A read of a maintenance encoding returns zero and pulses nothing.
- R11: A read of primary 7 with secondary 10 or 14 and sub-opcode 3 returns `clean_done` in bit 30 and zero elsewhere, with no pulse.
- R12: `rd_data` is zero whenever no read command is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_wr | input | 1 | 1 = write (move to coprocessor), 0 = read |
| cmd_crn | input | 4 | Primary register number |
| cmd_crm | input | 4 | Secondary register number |
| cmd_op2 | input | 3 | Sub-opcode |
| cmd_wdata | input | 32 | Write value |
| dabort_valid | input | 1 | Data abort occurred |
| dabort_fs | input | FSR_W | Data abort status code |
| dabort_addr | input | 32 | Data abort address |
| pabort_valid | input | 1 | Prefetch abort occurred |
| pabort_fs | input | FSR_W | Prefetch abort status code |
| clean_done | input | 1 | Test-and-clean completion status |
| rd_data | output | 32 | Read result, combinational |
| maint_pulse | output | 12 | One-hot maintenance command pulses |
| maint_arg | output | 32 | Write value of the last maintenance command |
| ctrl_out | output | 32 | Control register |
| ttb_out | output | 32 | Translation base, low 14 bits zero |
| dacr_out | output | 32 | Domain access register |
| pid_out | output | 7 | Process ID field |
| trace_pid | output | 32 | Context ID for trace |
| trace_pid_wr | output | 1 | Context ID write strobe |

## Verification
The assertions check on every cycle that maintenance pulses stay one-hot and follow only a write command, and that read commands never pulse. They also check that the translation base and context ID outputs carry the value written one cycle earlier, that data aborts load both the fault status and the fault address, that prefetch aborts leave the fault address unchanged, and that `rd_data` is zero when no read is present. Only the bench scenarios can show the full selector decode: which constant or register each encoding returns, that undefined encodings leave every register untouched, that an abort wins over a same-cycle software write, and how `clean_done` appears in a test-and-clean read.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DW        = 32;
  localparam int MAINT_N   = 12;
  localparam int TTB_LO    = 14;
  localparam int PID_W     = 7;
  localparam int CLEAN_BIT = 30;
  localparam int TLB_BASE  = 6;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_CTYPE, SEL_TCM, SEL_CTRL, SEL_TTB, SEL_DACR,
    SEL_DFSR, SEL_IFSR, SEL_FAR, SEL_DLOCK, SEL_ILOCK, SEL_TLOCK,
    SEL_PID, SEL_CTX, SEL_TCLEAN
  } sel_e;

  // Storage target chosen jointly by the three selector fields.
  function automatic sel_e reg_select(input logic [3:0] crn, input logic [3:0] crm,
                                      input logic [2:0] op2);
    sel_e s;
    s = SEL_NONE;
    if (crm == 4'd0) begin
      case (crn)
        4'd0:  s = (op2 == 3'd0) ? SEL_ID : (op2 == 3'd1) ? SEL_CTYPE :
                   (op2 == 3'd2) ? SEL_TCM : SEL_NONE;
        4'd1:  s = (op2 == 3'd0) ? SEL_CTRL : SEL_NONE;
        4'd2:  s = (op2 == 3'd0) ? SEL_TTB : SEL_NONE;
        4'd3:  s = (op2 == 3'd0) ? SEL_DACR : SEL_NONE;
        4'd5:  s = (op2 == 3'd0) ? SEL_DFSR : (op2 == 3'd1) ? SEL_IFSR : SEL_NONE;
        4'd6:  s = (op2 == 3'd0) ? SEL_FAR : SEL_NONE;
        4'd9:  s = (op2 == 3'd0) ? SEL_DLOCK : (op2 == 3'd1) ? SEL_ILOCK : SEL_NONE;
        4'd10: s = (op2 == 3'd0) ? SEL_TLOCK : SEL_NONE;
        4'd13: s = (op2 == 3'd0) ? SEL_PID : (op2 == 3'd1) ? SEL_CTX : SEL_NONE;
        default: s = SEL_NONE;
      endcase
    end else if (crn == 4'd7 && op2 == 3'd3 && (crm == 4'd10 || crm == 4'd14)) begin
      s = SEL_TCLEAN;
    end
    return s;
  endfunction

  // One-hot maintenance command for a write; zero for non-maintenance encodings.
  function automatic logic [MAINT_N-1:0] maint_decode(input logic [3:0] crn,
                                                      input logic [3:0] crm,
                                                      input logic [2:0] op2);
    logic [MAINT_N-1:0] m;
    int side;
    m = '0;
    side = -1;
    if (crn == 4'd7) begin
      case ({crm, op2})
        {4'd7,  3'd0}: m[0] = 1'b1;
        {4'd5,  3'd0}: m[1] = 1'b1;
        {4'd6,  3'd0}: m[2] = 1'b1;
        {4'd13, 3'd1}: m[3] = 1'b1;
        {4'd10, 3'd4}: m[4] = 1'b1;
        {4'd0,  3'd4}: m[5] = 1'b1;
        default: m = '0;
      endcase
    end else if (crn == 4'd8) begin
      case (crm)
        4'd7:    side = 0;
        4'd5:    side = 1;
        4'd6:    side = 2;
        default: side = -1;
      endcase
      if (side >= 0 && op2 <= 3'd1)
        m[TLB_BASE + 2*side + int'(op2)] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] ttb_keep(input logic [DW-1:0] v);
    return {v[DW-1:TTB_LO], {TTB_LO{1'b0}}};
  endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic               cmd_valid,
  input  logic               cmd_wr,
  input  logic [3:0]         cmd_crn,
  input  logic [3:0]         cmd_crm,
  input  logic [2:0]         cmd_op2,
  output sel_e               sel,
  output logic               wr_hit,
  output logic               rd_hit,
  output logic [MAINT_N-1:0] maint_hit
);
  always_comb begin
    sel       = reg_select(cmd_crn, cmd_crm, cmd_op2);
    wr_hit    = cmd_valid & cmd_wr;
    rd_hit    = cmd_valid & ~cmd_wr;
    maint_hit = wr_hit ? maint_decode(cmd_crn, cmd_crm, cmd_op2) : '0;
  end
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
  import sysreg_pkg::*;
#(
  parameter logic [31:0] CTRL_RESET = 32'h0005_0078,
  parameter int          FSR_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  sel_e             sel,
  input  logic [DW-1:0]    wdata,
  input  logic             dabort_valid,
  input  logic [FSR_W-1:0] dabort_fs,
  input  logic [DW-1:0]    dabort_addr,
  input  logic             pabort_valid,
  input  logic [FSR_W-1:0] pabort_fs,
  output logic [DW-1:0]    ctrl_q,
  output logic [DW-1:0]    ttb_q,
  output logic [DW-1:0]    dacr_q,
  output logic [FSR_W-1:0] dfsr_q,
  output logic [FSR_W-1:0] ifsr_q,
  output logic [DW-1:0]    far_q,
  output logic [DW-1:0]    dlock_q,
  output logic [DW-1:0]    ilock_q,
  output logic [DW-1:0]    tlock_q,
  output logic [PID_W-1:0] pid_q,
  output logic [DW-1:0]    ctx_q,
  output logic             ctx_wr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      ttb_q    <= '0;
      dacr_q   <= '0;
      dfsr_q   <= '0;
      ifsr_q   <= '0;
      far_q    <= '0;
      dlock_q  <= '0;
      ilock_q  <= '0;
      tlock_q  <= '0;
      pid_q    <= '0;
      ctx_q    <= '0;
      ctx_wr_q <= 1'b0;
    end else begin
      ctx_wr_q <= 1'b0;
      if (wr_en) begin
        case (sel)
          SEL_CTRL:  ctrl_q  <= wdata;
          SEL_TTB:   ttb_q   <= ttb_keep(wdata);
          SEL_DACR:  dacr_q  <= wdata;
          SEL_DFSR:  dfsr_q  <= wdata[FSR_W-1:0];
          SEL_IFSR:  ifsr_q  <= wdata[FSR_W-1:0];
          SEL_FAR:   far_q   <= wdata;
          SEL_DLOCK: dlock_q <= wdata;
          SEL_ILOCK: ilock_q <= wdata;
          SEL_TLOCK: tlock_q <= wdata;
          SEL_PID:   pid_q   <= wdata[DW-1 -: PID_W];
          SEL_CTX: begin
            ctx_q    <= wdata;
            ctx_wr_q <= 1'b1;
          end
          default: ;
        endcase
      end
      // Hardware fault capture overrides a same-cycle software write.
      if (dabort_valid) begin
        dfsr_q <= dabort_fs;
        far_q  <= dabort_addr;
      end
      if (pabort_valid)
        ifsr_q <= pabort_fs;
    end
  end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter logic [31:0] ID_VALUE    = 32'h7A10_C3E1,
  parameter logic [31:0] CTYPE_VALUE = 32'h1D15_2152,
  parameter logic [31:0] TCM_VALUE   = 32'h0001_0001,
  parameter logic [31:0] CTRL_RESET  = 32'h0005_0078,
  parameter int          FSR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_wr,
  input  logic [3:0]       cmd_crn,
  input  logic [3:0]       cmd_crm,
  input  logic [2:0]       cmd_op2,
  input  logic [31:0]      cmd_wdata,
  input  logic             dabort_valid,
  input  logic [FSR_W-1:0] dabort_fs,
  input  logic [31:0]      dabort_addr,
  input  logic             pabort_valid,
  input  logic [FSR_W-1:0] pabort_fs,
  input  logic             clean_done,
  output logic [31:0]      rd_data,
  output logic [11:0]      maint_pulse,
  output logic [31:0]      maint_arg,
  output logic [31:0]      ctrl_out,
  output logic [31:0]      ttb_out,
  output logic [31:0]      dacr_out,
  output logic [6:0]       pid_out,
  output logic [31:0]      trace_pid,
  output logic             trace_pid_wr
);
  localparam int FS_PAD  = DW - FSR_W;
  localparam int PID_PAD = DW - PID_W;

  sel_e               sel;
  logic               wr_hit;
  logic               rd_hit;
  logic [MAINT_N-1:0] maint_hit;
  logic [DW-1:0]      ctrl_q, ttb_q, dacr_q, far_q, dlock_q, ilock_q, tlock_q, ctx_q;
  logic [FSR_W-1:0]   dfsr_q, ifsr_q;
  logic [PID_W-1:0]   pid_q;
  logic               ctx_wr_q;

  sysreg_decode u_decode (
    .cmd_valid (cmd_valid),
    .cmd_wr    (cmd_wr),
    .cmd_crn   (cmd_crn),
    .cmd_crm   (cmd_crm),
    .cmd_op2   (cmd_op2),
    .sel       (sel),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .maint_hit (maint_hit)
  );

  sysreg_store #(.CTRL_RESET(CTRL_RESET), .FSR_W(FSR_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_hit),
    .sel          (sel),
    .wdata        (cmd_wdata),
    .dabort_valid (dabort_valid),
    .dabort_fs    (dabort_fs),
    .dabort_addr  (dabort_addr),
    .pabort_valid (pabort_valid),
    .pabort_fs    (pabort_fs),
    .ctrl_q       (ctrl_q),
    .ttb_q        (ttb_q),
    .dacr_q       (dacr_q),
    .dfsr_q       (dfsr_q),
    .ifsr_q       (ifsr_q),
    .far_q        (far_q),
    .dlock_q      (dlock_q),
    .ilock_q      (ilock_q),
    .tlock_q      (tlock_q),
    .pid_q        (pid_q),
    .ctx_q        (ctx_q),
    .ctx_wr_q     (ctx_wr_q)
  );

  // Combinational read path.
  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      case (sel)
        SEL_ID:     rd_data = ID_VALUE;
        SEL_CTYPE:  rd_data = CTYPE_VALUE;
        SEL_TCM:    rd_data = TCM_VALUE;
        SEL_CTRL:   rd_data = ctrl_q;
        SEL_TTB:    rd_data = ttb_q;
        SEL_DACR:   rd_data = dacr_q;
        SEL_DFSR:   rd_data = {{FS_PAD{1'b0}}, dfsr_q};
        SEL_IFSR:   rd_data = {{FS_PAD{1'b0}}, ifsr_q};
        SEL_FAR:    rd_data = far_q;
        SEL_DLOCK:  rd_data = dlock_q;
        SEL_ILOCK:  rd_data = ilock_q;
        SEL_TLOCK:  rd_data = tlock_q;
        SEL_PID:    rd_data = {pid_q, {PID_PAD{1'b0}}};
        SEL_CTX:    rd_data = ctx_q;
        SEL_TCLEAN: rd_data[CLEAN_BIT] = clean_done;
        default:    rd_data = '0;
      endcase
    end
  end

  // Registered one-cycle command strobes, one flop per operation.
  for (genvar g = 0; g < MAINT_N; g++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) maint_pulse[g] <= 1'b0;
      else        maint_pulse[g] <= maint_hit[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          maint_arg <= '0;
    else if (|maint_hit) maint_arg <= cmd_wdata;
  end

  assign ctrl_out     = ctrl_q;
  assign ttb_out      = ttb_q;
  assign dacr_out     = dacr_q;
  assign pid_out      = pid_q;
  assign trace_pid    = ctx_q;
  assign trace_pid_wr = ctx_wr_q;
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk #(
  parameter int FSR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_wr,
  input logic [3:0]       cmd_crn,
  input logic [3:0]       cmd_crm,
  input logic [2:0]       cmd_op2,
  input logic [31:0]      cmd_wdata,
  input logic             dabort_valid,
  input logic [FSR_W-1:0] dabort_fs,
  input logic [31:0]      dabort_addr,
  input logic             pabort_valid,
  input logic [31:0]      rd_data,
  input logic [11:0]      maint_pulse,
  input logic [31:0]      ttb_out,
  input logic [31:0]      trace_pid,
  input logic             trace_pid_wr,
  input logic [31:0]      far_q,
  input logic [FSR_W-1:0] dfsr_q
);
  logic ttb_wr;
  assign ttb_wr = cmd_valid && cmd_wr && cmd_crn == 4'd2 && cmd_crm == 4'd0 && cmd_op2 == 3'd0;

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(maint_pulse)); // R6
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (maint_pulse != 12'd0) |-> $past(cmd_valid && cmd_wr)); // R10
  AST_READ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_wr) |=> (maint_pulse == 12'd0)); // R10
  AST_TTB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ttb_wr |=> (ttb_out == ($past(cmd_wdata) & 32'hFFFF_C000))); // R2
  AST_FAR_DABORT: assert property (@(posedge clk) disable iff (!rst_n)
    dabort_valid |=> (far_q == $past(dabort_addr))); // R5
  AST_FAR_PABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (pabort_valid && !dabort_valid && !(cmd_valid && cmd_wr && cmd_crn == 4'd6))
      |=> $stable(far_q)); // R5
  AST_DFSR_DABORT: assert property (@(posedge clk) disable iff (!rst_n)
    dabort_valid |=> (dfsr_q == $past(dabort_fs))); // R4
  AST_TRACE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    trace_pid_wr |-> (trace_pid == $past(cmd_wdata))); // R9
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_wr) |-> (rd_data == 32'd0)); // R12
endmodule

bind sysreg_bank sysreg_bank_chk #(.FSR_W(FSR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_wr       (cmd_wr),
  .cmd_crn      (cmd_crn),
  .cmd_crm      (cmd_crm),
  .cmd_op2      (cmd_op2),
  .cmd_wdata    (cmd_wdata),
  .dabort_valid (dabort_valid),
  .dabort_fs    (dabort_fs),
  .dabort_addr  (dabort_addr),
  .pabort_valid (pabort_valid),
  .rd_data      (rd_data),
  .maint_pulse  (maint_pulse),
  .ttb_out      (ttb_out),
  .trace_pid    (trace_pid),
  .trace_pid_wr (trace_pid_wr),
  .far_q        (far_q),
  .dfsr_q       (dfsr_q)
);

// File: tb/sysreg_bank_bench.sv
`timescale 1ns/1ps
module sysreg_bank_bench;
  localparam logic [31:0] B_ID   = 32'h3C9E_0417;
  localparam logic [31:0] B_CT   = 32'h0A14_6C28;
  localparam logic [31:0] B_TCM  = 32'h0000_0005;
  localparam logic [31:0] B_CTRL = 32'h0005_0078;

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [3:0]  crn;
    logic [3:0]  crm;
    logic [2:0]  op2;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [11:0] pl;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  1'b0, 4'd0,  4'd0,  3'd0, 32'h0,         B_ID,          12'h000}, // R1
    '{4'd1,  1'b0, 4'd0,  4'd0,  3'd1, 32'h0,         B_CT,          12'h000}, // R1
    '{4'd1,  1'b0, 4'd0,  4'd0,  3'd2, 32'h0,         B_TCM,         12'h000}, // R1
    '{4'd10, 1'b0, 4'd0,  4'd0,  3'd5, 32'h0,         32'h0,         12'h000}, // R10
    '{4'd1,  1'b1, 4'd0,  4'd0,  3'd0, 32'hFFFF_FFFF, 32'h0,         12'h000}, // R1
    '{4'd1,  1'b0, 4'd0,  4'd0,  3'd0, 32'h0,         B_ID,          12'h000}, // R1
    '{4'd3,  1'b0, 4'd1,  4'd0,  3'd0, 32'h0,         B_CTRL,        12'h000}, // R3
    '{4'd3,  1'b1, 4'd1,  4'd0,  3'd0, 32'h0000_1005, 32'h0,         12'h000}, // R3
    '{4'd3,  1'b0, 4'd1,  4'd0,  3'd0, 32'h0,         32'h0000_1005, 12'h000}, // R3
    '{4'd10, 1'b1, 4'd1,  4'd0,  3'd2, 32'hFFFF_FFFF, 32'h0,         12'h000}, // R10
    '{4'd10, 1'b0, 4'd1,  4'd0,  3'd0, 32'h0,         32'h0000_1005, 12'h000}, // R10
    '{4'd2,  1'b1, 4'd2,  4'd0,  3'd0, 32'hDEAD_BEEF, 32'h0,         12'h000}, // R2
    '{4'd2,  1'b0, 4'd2,  4'd0,  3'd0, 32'h0,         32'hDEAD_8000, 12'h000}, // R2
    '{4'd3,  1'b1, 4'd3,  4'd0,  3'd0, 32'h5555_AAAA, 32'h0,         12'h000}, // R3
    '{4'd3,  1'b0, 4'd3,  4'd0,  3'd0, 32'h0,         32'h5555_AAAA, 12'h000}, // R3
    '{4'd4,  1'b1, 4'd5,  4'd0,  3'd0, 32'h1234_56F3, 32'h0,         12'h000}, // R4
    '{4'd4,  1'b0, 4'd5,  4'd0,  3'd0, 32'h0,         32'h0000_00F3, 12'h000}, // R4
    '{4'd4,  1'b1, 4'd5,  4'd0,  3'd1, 32'h0000_00A5, 32'h0,         12'h000}, // R4
    '{4'd4,  1'b0, 4'd5,  4'd0,  3'd1, 32'h0,         32'h0000_00A5, 12'h000}, // R4
    '{4'd4,  1'b0, 4'd5,  4'd0,  3'd0, 32'h0,         32'h0000_00F3, 12'h000}, // R4
    '{4'd5,  1'b1, 4'd6,  4'd0,  3'd0, 32'hCAFE_0004, 32'h0,         12'h000}, // R5
    '{4'd5,  1'b0, 4'd6,  4'd0,  3'd0, 32'h0,         32'hCAFE_0004, 12'h000}, // R5
    '{4'd3,  1'b1, 4'd9,  4'd0,  3'd0, 32'h0000_000E, 32'h0,         12'h000}, // R3
    '{4'd3,  1'b1, 4'd9,  4'd0,  3'd1, 32'h0000_0003, 32'h0,         12'h000}, // R3
    '{4'd3,  1'b0, 4'd9,  4'd0,  3'd0, 32'h0,         32'h0000_000E, 12'h000}, // R3
    '{4'd3,  1'b0, 4'd9,  4'd0,  3'd1, 32'h0,         32'h0000_0003, 12'h000}, // R3
    '{4'd3,  1'b1, 4'd10, 4'd0,  3'd0, 32'h1C00_0000, 32'h0,         12'h000}, // R3
    '{4'd3,  1'b0, 4'd10, 4'd0,  3'd0, 32'h0,         32'h1C00_0000, 12'h000}, // R3
    '{4'd8,  1'b1, 4'd13, 4'd0,  3'd0, 32'hFFFF_FFFF, 32'h0,         12'h000}, // R8
    '{4'd8,  1'b0, 4'd13, 4'd0,  3'd0, 32'h0,         32'hFE00_0000, 12'h000}, // R8
    '{4'd6,  1'b1, 4'd7,  4'd7,  3'd0, 32'h0,         32'h0,         12'h001}, // R6
    '{4'd6,  1'b1, 4'd7,  4'd5,  3'd0, 32'h0,         32'h0,         12'h002}, // R6
    '{4'd6,  1'b1, 4'd7,  4'd6,  3'd0, 32'h0,         32'h0,         12'h004}, // R6
    '{4'd6,  1'b1, 4'd7,  4'd13, 3'd1, 32'h0,         32'h0,         12'h008}, // R6
    '{4'd6,  1'b1, 4'd7,  4'd10, 3'd4, 32'h0,         32'h0,         12'h010}, // R6
    '{4'd6,  1'b1, 4'd7,  4'd0,  3'd4, 32'h0,         32'h0,         12'h020}, // R6
    '{4'd7,  1'b1, 4'd8,  4'd7,  3'd0, 32'h0,         32'h0,         12'h040}, // R7
    '{4'd7,  1'b1, 4'd8,  4'd7,  3'd1, 32'h0,         32'h0,         12'h080}, // R7
    '{4'd7,  1'b1, 4'd8,  4'd5,  3'd0, 32'h0,         32'h0,         12'h100}, // R7
    '{4'd7,  1'b1, 4'd8,  4'd5,  3'd1, 32'h0,         32'h0,         12'h200}, // R7
    '{4'd7,  1'b1, 4'd8,  4'd6,  3'd0, 32'h0,         32'h0,         12'h400}, // R7
    '{4'd7,  1'b1, 4'd8,  4'd6,  3'd1, 32'h0,         32'h0,         12'h800}, // R7
    '{4'd10, 1'b1, 4'd7,  4'd3,  3'd3, 32'h0,         32'h0,         12'h000}, // R10
    '{4'd10, 1'b1, 4'd8,  4'd7,  3'd2, 32'h0,         32'h0,         12'h000}, // R10
    '{4'd10, 1'b0, 4'd7,  4'd7,  3'd0, 32'h0,         32'h0,         12'h000}, // R10
    '{4'd10, 1'b1, 4'd4,  4'd0,  3'd0, 32'h1111_1111, 32'h0,         12'h000}, // R10
    '{4'd10, 1'b0, 4'd4,  4'd0,  3'd0, 32'h0,         32'h0,         12'h000}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_wr = 1'b0;
  logic [3:0]  cmd_crn = '0, cmd_crm = '0;
  logic [2:0]  cmd_op2 = '0;
  logic [31:0] cmd_wdata = '0;
  logic        dabort_valid = 1'b0, pabort_valid = 1'b0, clean_done = 1'b0;
  logic [7:0]  dabort_fs = '0, pabort_fs = '0;
  logic [31:0] dabort_addr = '0;
  logic [31:0] rd_data, maint_arg, ctrl_out, ttb_out, dacr_out, trace_pid;
  logic [11:0] maint_pulse;
  logic [6:0]  pid_out;
  logic        trace_pid_wr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] rd_s;

  always #5 clk = ~clk;

  sysreg_bank #(.ID_VALUE(B_ID), .CTYPE_VALUE(B_CT), .TCM_VALUE(B_TCM),
                .CTRL_RESET(B_CTRL), .FSR_W(8)) u_sysreg_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .cmd_crn(cmd_crn), .cmd_crm(cmd_crm), .cmd_op2(cmd_op2), .cmd_wdata(cmd_wdata),
    .dabort_valid(dabort_valid), .dabort_fs(dabort_fs), .dabort_addr(dabort_addr),
    .pabort_valid(pabort_valid), .pabort_fs(pabort_fs), .clean_done(clean_done),
    .rd_data(rd_data), .maint_pulse(maint_pulse), .maint_arg(maint_arg),
    .ctrl_out(ctrl_out), .ttb_out(ttb_out), .dacr_out(dacr_out), .pid_out(pid_out),
    .trace_pid(trace_pid), .trace_pid_wr(trace_pid_wr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic run_cmd(input logic wr, input logic [3:0] crn, input logic [3:0] crm,
                         input logic [2:0] op2, input logic [31:0] wd);
    cmd_valid = 1'b1; cmd_wr = wr; cmd_crn = crn; cmd_crm = crm; cmd_op2 = op2;
    cmd_wdata = wd;
    #2 rd_s = rd_data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired before all requirement checks ended");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check(pid_out == 7'd0, "R8 reset pid", {25'd0, pid_out}, 32'd0);
    check(ctrl_out == B_CTRL, "R3 reset ctrl", ctrl_out, B_CTRL);
    check(maint_pulse == 12'd0 && !trace_pid_wr, "R6 reset strobes",
          {19'd0, trace_pid_wr, maint_pulse}, 32'd0);
    check(rd_data == 32'd0, "R12 idle read", rd_data, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i].wr, VEC[i].crn, VEC[i].crm, VEC[i].op2, VEC[i].wd);
      if (!VEC[i].wr)
        check(rd_s == VEC[i].rd, $sformatf("R%0d vec %0d read", VEC[i].req, i), rd_s, VEC[i].rd);
      check(maint_pulse == VEC[i].pl, $sformatf("R%0d vec %0d pulse", VEC[i].req, i),
            {20'd0, maint_pulse}, {20'd0, VEC[i].pl});
      if (VEC[i].wr && VEC[i].pl == 12'd0)
        check(rd_s == 32'd0, "R12 read data during write", rd_s, 32'd0);
    end
    check(ttb_out == 32'hDEAD_8000, "R2 ttb_out", ttb_out, 32'hDEAD_8000);
    check(dacr_out == 32'h5555_AAAA, "R3 dacr_out", dacr_out, 32'h5555_AAAA);
    check(ctrl_out == 32'h0000_1005, "R3 ctrl_out", ctrl_out, 32'h0000_1005);
    check(pid_out == 7'h7F, "R8 pid_out", {25'd0, pid_out}, 32'h7F);

    // R6 / R7 argument capture
    run_cmd(1'b1, 4'd7, 4'd13, 3'd1, 32'h0000_4440);
    check(maint_arg == 32'h0000_4440, "R6 maint_arg", maint_arg, 32'h0000_4440);
    run_cmd(1'b1, 4'd8, 4'd6, 3'd1, 32'h8000_1000);
    check(maint_arg == 32'h8000_1000 && maint_pulse == 12'h800, "R7 maint_arg",
          maint_arg, 32'h8000_1000);
    check(maint_pulse == 12'h800, "R7 entry pulse", {20'd0, maint_pulse}, 32'h800);

    // R9 context ID trace strobe
    run_cmd(1'b1, 4'd13, 4'd0, 3'd1, 32'h00C0_FFEE);
    check(trace_pid == 32'h00C0_FFEE, "R9 trace value", trace_pid, 32'h00C0_FFEE);
    check(trace_pid_wr == 1'b1, "R9 strobe high", {31'd0, trace_pid_wr}, 32'd1);
    @(negedge clk);
    check(trace_pid_wr == 1'b0, "R9 strobe one cycle", {31'd0, trace_pid_wr}, 32'd0);
    run_cmd(1'b0, 4'd13, 4'd0, 3'd1, 32'h0);
    check(rd_s == 32'h00C0_FFEE, "R9 context read", rd_s, 32'h00C0_FFEE);

    // R4 / R5 data abort
    dabort_valid = 1'b1; dabort_fs = 8'h2D; dabort_addr = 32'h1234_5678;
    @(negedge clk);
    dabort_valid = 1'b0; dabort_addr = 32'hFFFF_0000;
    run_cmd(1'b0, 4'd5, 4'd0, 3'd0, 32'h0);
    check(rd_s == 32'h2D, "R4 data abort status", rd_s, 32'h2D);
    run_cmd(1'b0, 4'd6, 4'd0, 3'd0, 32'h0);
    check(rd_s == 32'h1234_5678, "R5 data abort address", rd_s, 32'h1234_5678);

    // R4 / R5 prefetch abort leaves the address alone
    pabort_valid = 1'b1; pabort_fs = 8'h17;
    @(negedge clk);
    pabort_valid = 1'b0;
    run_cmd(1'b0, 4'd5, 4'd0, 3'd1, 32'h0);
    check(rd_s == 32'h17, "R4 prefetch abort status", rd_s, 32'h17);
    run_cmd(1'b0, 4'd6, 4'd0, 3'd0, 32'h0);
    check(rd_s == 32'h1234_5678, "R5 prefetch abort keeps address", rd_s, 32'h1234_5678);

    // R4 abort wins over same-cycle software write
    dabort_valid = 1'b1; dabort_fs = 8'h0B; dabort_addr = 32'h0000_0ABC;
    run_cmd(1'b1, 4'd5, 4'd0, 3'd0, 32'h0000_0011);
    dabort_valid = 1'b0;
    run_cmd(1'b0, 4'd5, 4'd0, 3'd0, 32'h0);
    check(rd_s == 32'h0B, "R4 abort priority", rd_s, 32'h0B);

    // R11 test-and-clean status
    clean_done = 1'b0;
    run_cmd(1'b0, 4'd7, 4'd10, 3'd3, 32'h0);
    check(rd_s == 32'h0, "R11 clean busy", rd_s, 32'h0);
    clean_done = 1'b1;
    run_cmd(1'b0, 4'd7, 4'd14, 3'd3, 32'h0);
    check(rd_s == 32'h4000_0000, "R11 clean done", rd_s, 32'h4000_0000);
    check(maint_pulse == 12'd0, "R11 no pulse", {20'd0, maint_pulse}, 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule